// File: doc/BRIEF.md
# TDM Time Slot Assigner Sequencer

This block divides a time-division-multiplexed serial frame into groups of bits or bytes. Two programmable route tables, one for receive and one for transmit, hold 16 entries each. Every entry names a destination channel, a group length and a unit size. A frame starts on a sync pulse. Both tables are then walked entry by entry on the serial clock. Received bits are handed to one of six channel ports. The transmit pin is driven from the bit that the selected channel presents.

An entry can also mark its group as unsupported. During such a group nothing is received and the transmit pin is released. Each entry can raise any of four strobe outputs for the length of its group. A sync that arrives in the middle of a frame halts the sequencer and raises an error until the following sync. The host fills the tables through a simple write port while no frame that uses those entries is running.

Top module: `tsa_seq`

## Requirements
- R1: While rst_ni is low, and after reset until the first sync, ch_rx_vld_o, tx_oe_o, strb_o and err_o are all zero.
- R2: An entry word has chan in bits [2:0], cnt in [6:3], a unit flag in [7], a last flag in [8] and strobe selects in [12:9]. A group lasts cnt+1 units. The unit is one bit when the flag is 0 and eight bits when it is 1, so groups run from 1 to 128 bits.
- R3: Frame bits are counted on clk_i rising edges. The edge that samples sync_i high while the sequencer is idle or halted starts the frame. Bit i of the frame is the rxd_i value sampled i+1 edges later. For a receive group whose chan is 1 to 6, ch_rx_vld_o is one-hot at bit chan-1 and ch_rx_bit_o holds that bit, both registered on the sampling edge.
- R4: A group whose chan is 0 or 7 is unsupported. In the receive table it raises no ch_rx_vld_o bit. In the transmit table it holds tx_oe_o low.
- R5: For a transmit group with chan 1 to 6, tx_oe_o is high and txd_o equals ch_tx_i[chan-1]. Both are updated on the falling edge that precedes the rising edge at which the bit is due.
- R6: After the last bit of the entry with the last flag set, the sequencer idles until the next sync. While idle, ch_rx_vld_o, tx_oe_o and strb_o stay zero.
- R7: A sync sampled on the edge that takes the final bit of the frame starts the next frame straight away, and err_o stays low.
- R8: A sync sampled at any other edge while a frame runs sets err_o. That bit is not delivered. Reception, transmission and strobes stop. The next sync clears err_o and starts a new frame from entry 0.
- R9: strb_o is the bitwise OR of the strobe selects of the active receive entry and the active transmit entry, ANDed with strb_en_i. The receive part changes on the rising edge and the transmit part on the falling edge.
- R10: A write with wr_en_i high stores wr_data_i at wr_addr_i. It goes to the transmit table when wr_tx_i is 1 and to the receive table when wr_tx_i is 0, and it leaves the other table untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | serial clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| sync_i | input | 1 | frame sync, sampled on the rising edge |
| rxd_i | input | 1 | serial receive data |
| ch_tx_i | input | 6 | transmit bit presented by each channel (bit n is channel n+1) |
| wr_en_i | input | 1 | table write strobe |
| wr_tx_i | input | 1 | 1 selects the transmit table, 0 the receive table |
| wr_addr_i | input | 4 | entry address |
| wr_data_i | input | 13 | entry word |
| strb_en_i | input | 4 | strobe pin enables |
| ch_rx_vld_o | output | 6 | one-hot receive valid per channel |
| ch_rx_bit_o | output | 1 | received bit for the valid channel |
| txd_o | output | 1 | transmit data |
| tx_oe_o | output | 1 | transmit pin drive enable |
| strb_o | output | 4 | strobe outputs |
| err_o | output | 1 | sync error, held until the recovering sync |

## Verification
A receive result for frame bit i is checked 1 ns after the rising edge that samples that bit, which is i+1 edges after the starting sync edge. At that point the valid register has just been loaded. Transmit drive and strobes for bit i are checked 6 ns after the rising edge that opens bit i, so the falling-edge registers have already updated. err_o is checked 1 ns after the edge that samples the early sync. The bench keeps its own copy of every entry it writes. From those copies it expands the expected channel and strobe for each frame bit, and only then does it drive the frame.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
package tsa_pkg;
  localparam int CH_W  = 3;
  localparam int CNT_W = 4;
  localparam int STB_N = 4;
  localparam int N_CH  = 6;
  localparam int LEN_W = CNT_W + 3;

  typedef struct packed {
    logic [STB_N-1:0] strb;
    logic             last;
    logic             byt;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  chan;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);
endpackage

// File: rtl/tsa_table.sv
`timescale 1ns/1ps
module tsa_table import tsa_pkg::*; #(
  parameter int N_ENT = 16,
  localparam int AW = $clog2(N_ENT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  ent_t          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output ent_t          rdata_o
);
  ent_t mem_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_ENT; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tsa_walk.sv
`timescale 1ns/1ps
module tsa_walk import tsa_pkg::*; #(
  parameter int N_ENT = 16,
  localparam int AW = $clog2(N_ENT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  ent_t          ent_i,
  output logic [AW-1:0] idx_o,
  output logic          run_o,
  output logic          tk_o,
  output logic          err_o
);
  typedef enum logic [1:0] {W_IDLE, W_RUN, W_ERR} wst_e;

  wst_e             st_q;
  logic [AW-1:0]    idx_q;
  logic [LEN_W-1:0] bit_q;
  logic [LEN_W-1:0] len_m1;
  logic             done, fin;

  // length-1 in bits: cnt, or cnt*8+7 for byte units
  assign len_m1 = ent_i.byt ? {ent_i.cnt, 3'b111} : LEN_W'(ent_i.cnt);
  assign done   = bit_q == len_m1;
  assign fin    = done && ent_i.last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= W_IDLE;
      idx_q <= '0;
      bit_q <= '0;
    end else begin
      case (st_q)
        W_RUN: begin
          if (sync_i && !fin) begin
            st_q <= W_ERR;
          end else if (done) begin
            bit_q <= '0;
            if (ent_i.last) begin
              idx_q <= '0;
              st_q  <= sync_i ? W_RUN : W_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        default: begin
          if (sync_i) begin
            st_q  <= W_RUN;
            idx_q <= '0;
            bit_q <= '0;
          end
        end
      endcase
    end
  end

  assign idx_o = idx_q;
  assign run_o = st_q == W_RUN;
  assign tk_o  = run_o && (!sync_i || fin);
  assign err_o = st_q == W_ERR;
endmodule

// File: rtl/tsa_seq.sv
`timescale 1ns/1ps
module tsa_seq import tsa_pkg::*; #(
  parameter int N_ENT = 16,
  localparam int AW = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             rxd_i,
  input  logic [N_CH-1:0]  ch_tx_i,
  input  logic             wr_en_i,
  input  logic             wr_tx_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [ENT_W-1:0] wr_data_i,
  input  logic [STB_N-1:0] strb_en_i,
  output logic [N_CH-1:0]  ch_rx_vld_o,
  output logic             ch_rx_bit_o,
  output logic             txd_o,
  output logic             tx_oe_o,
  output logic [STB_N-1:0] strb_o,
  output logic             err_o
);
  // index 0 = receive, 1 = transmit
  ent_t          ent  [2];
  logic [AW-1:0] idx  [2];
  logic          run  [2];
  logic          tk   [2];
  logic          werr [2];
  logic          rte  [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    tsa_table #(.N_ENT(N_ENT)) i_table (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_tx_i == 1'(d))),
      .waddr_i (wr_addr_i),
      .wdata_i (ent_t'(wr_data_i)),
      .raddr_i (idx[d]),
      .rdata_o (ent[d])
    );
    tsa_walk #(.N_ENT(N_ENT)) i_walk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_i),
      .ent_i  (ent[d]),
      .idx_o  (idx[d]),
      .run_o  (run[d]),
      .tk_o   (tk[d]),
      .err_o  (werr[d])
    );
    assign rte[d] = (ent[d].chan != '0) && (int'(ent[d].chan) <= N_CH);
  end

  logic [CH_W-1:0]  rx_sel, tx_sel;
  logic [STB_N-1:0] rx_stb, tx_stb_q;

  assign rx_sel = ent[0].chan - 1'b1;
  assign tx_sel = ent[1].chan - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_rx_vld_o <= '0;
      ch_rx_bit_o <= 1'b0;
    end else begin
      ch_rx_vld_o <= '0;
      if (tk[0] && rte[0]) begin
        ch_rx_vld_o <= N_CH'(1) << rx_sel;
        ch_rx_bit_o <= rxd_i;
      end
    end
  end

  // transmit side launches on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_oe_o  <= 1'b0;
      txd_o    <= 1'b0;
      tx_stb_q <= '0;
    end else begin
      tx_oe_o  <= run[1] && rte[1];
      txd_o    <= run[1] && rte[1] && ch_tx_i[tx_sel];
      tx_stb_q <= run[1] ? ent[1].strb : '0;
    end
  end

  assign rx_stb = run[0] ? ent[0].strb : '0;
  assign strb_o = strb_en_i & (rx_stb | tx_stb_q);
  assign err_o  = werr[0] | werr[1];
endmodule

// File: rtl/tsa_chk.sv
`timescale 1ns/1ps
module tsa_chk import tsa_pkg::*; (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sync_i,
  input logic            err_o,
  input logic            tx_oe_o,
  input logic [N_CH-1:0] ch_rx_vld_o
);
  a_r3_vld_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_rx_vld_o));

  a_r8_err_from_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(sync_i));

  a_r8_no_rx_in_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ch_rx_vld_o == '0);

  a_r8_no_tx_in_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !tx_oe_o);
endmodule

bind tsa_seq tsa_chk i_tsa_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .err_o       (err_o),
  .tx_oe_o     (tx_oe_o),
  .ch_rx_vld_o (ch_rx_vld_o)
);

// File: tb/test_tsa_seq.sv
`timescale 1ns/1ps
module test_tsa_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        rxd = 1'b0;
  logic [5:0]  ch_tx = 6'b011010;
  logic        wr_en = 1'b0;
  logic        wr_tx = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [3:0]  strb_en = 4'hF;
  logic [5:0]  vld;
  logic        rbit, txd, oe, err;
  logic [3:0]  strb;

  int checks = 0;
  int errors = 0;

  logic [12:0] tbl [2][16];
  int          e_ch [2][256];
  logic [3:0]  e_st [2][256];
  int          flen;

  always #4 clk = ~clk;

  tsa_seq i_tsa_seq (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .rxd_i(rxd), .ch_tx_i(ch_tx),
    .wr_en_i(wr_en), .wr_tx_i(wr_tx), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .strb_en_i(strb_en), .ch_rx_vld_o(vld), .ch_rx_bit_o(rbit), .txd_o(txd),
    .tx_oe_o(oe), .strb_o(strb), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pat(input int i);
    return logic'(((i * 7 + 3) >> 1) & 1);
  endfunction

  function automatic bit sup(input int c);
    return c >= 1 && c <= 6;
  endfunction

  function automatic logic [12:0] mk(input int st, input bit last, input bit byt,
                                     input int cnt, input int ch);
    return {4'(st), last, byt, 4'(cnt), 3'(ch)};
  endfunction

  task automatic wr(input bit tx, input int a, input logic [12:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_tx = tx; wr_addr = 4'(a); wr_data = d;
    tbl[tx][a] = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  // expected channel and strobe per frame bit, from the entry words (R2)
  task automatic expand();
    for (int d = 0; d < 2; d++) begin
      int n = 0;
      for (int k = 0; k < 16; k++) begin
        int l = (int'(tbl[d][k][6:3]) + 1) * (tbl[d][k][7] ? 8 : 1);
        for (int b = 0; b < l; b++) begin
          e_ch[d][n] = int'(tbl[d][k][2:0]);
          e_st[d][n] = tbl[d][k][12:9];
          n++;
        end
        if (tbl[d][k][8]) break;
      end
      flen = n;
    end
  endtask

  task automatic chk_rx(input int i);
    int c = e_ch[0][i];
    int ev = sup(c) ? (1 << (c - 1)) : 0;
    chk(vld == 6'(ev), sup(c) ? "R3 rx valid" : "R4 rx unsupported", int'(vld), ev);
    if (sup(c)) chk(rbit == pat(i), "R3 rx bit", int'(rbit), int'(pat(i)));
  endtask

  task automatic chk_tx(input int i);
    int c = e_ch[1][i];
    logic [3:0] es = strb_en & (e_st[0][i] | e_st[1][i]);
    chk(oe == sup(c), sup(c) ? "R5 tx enable" : "R4 tx released", int'(oe), int'(sup(c)));
    if (sup(c)) chk(txd == ch_tx[c-1], "R5 tx data", int'(txd), int'(ch_tx[c-1]));
    chk(strb == es, "R9 strobe", int'(strb), int'(es));
  endtask

  // runs a frame; b2b raises sync for the final bit
  task automatic run_frame(input bit b2b);
    expand();
    @(posedge clk); #2 sync = 1'b1;
    @(posedge clk);
    #2 sync = 1'b0; rxd = pat(0);
    #4 chk_tx(0);
    for (int i = 0; i < flen; i++) begin
      @(posedge clk);
      #1 chk_rx(i);
      #1 sync = b2b && (i == flen - 2);
      rxd = pat(i + 1);
      #4;
      if (i < flen - 1) chk_tx(i + 1);
      else if (!b2b) begin
        chk(oe == 1'b0, "R6 idle tx", int'(oe), 0);
        chk(strb == 4'h0, "R6 idle strobe", int'(strb), 0);
      end
    end
    if (b2b) begin
      chk(err == 1'b0, "R7 no error", int'(err), 0);
      chk_tx(0);
      @(posedge clk); #1 chk_rx(0);
    end else begin
      @(posedge clk); #1;
      chk(vld == 6'h0, "R6 idle rx", int'(vld), 0);
    end
    chk(err == 1'b0, "R8 err low", int'(err), 0);
  endtask

  task automatic t_reset();
    #1;
    chk(vld == 0 && oe == 0 && strb == 0 && err == 0, "R1 in reset",
        int'({vld, oe, strb, err}), 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(vld == 0 && oe == 0 && strb == 0 && err == 0, "R1 after reset",
        int'({vld, oe, strb, err}), 0);
  endtask

  task automatic t_mixed();
    wr(0, 0, mk(1, 0, 0, 2, 1));
    wr(0, 1, mk(0, 0, 0, 0, 0));
    wr(0, 2, mk(4, 1, 1, 0, 6));
    wr(1, 0, mk(2, 0, 0, 3, 3));
    wr(1, 1, mk(0, 0, 0, 3, 7));
    wr(1, 2, mk(8, 1, 0, 3, 5));
    repeat (4) @(posedge clk); #6;
    chk(oe == 0 && strb == 0, "R10 writes start nothing", int'({oe, strb}), 0);
    run_frame(0);
  endtask

  task automatic t_strobe_off();
    strb_en = 4'b0101;
    run_frame(0);
    strb_en = 4'hF;
  endtask

  task automatic t_b2b();
    run_frame(1);
    repeat (flen + 2) @(posedge clk);
    #1 chk(err == 1'b0, "R7 no error after", int'(err), 0);
  endtask

  task automatic t_error();
    @(posedge clk); #2 sync = 1'b1;
    @(posedge clk); #2 sync = 1'b0;
    repeat (3) @(posedge clk);
    #2 sync = 1'b1;
    @(posedge clk);
    #1 chk(err == 1'b1, "R8 err set", int'(err), 1);
    chk(vld == 6'h0, "R8 bit dropped", int'(vld), 0);
    #1 sync = 1'b0;
    repeat (20) @(posedge clk);
    #6;
    chk(err == 1'b1, "R8 err held", int'(err), 1);
    chk(oe == 1'b0 && strb == 4'h0, "R8 halted", int'({oe, strb}), 0);
    run_frame(0);
  endtask

  task automatic t_long();
    wr(0, 0, mk(3, 0, 0, 15, 2));
    wr(0, 1, mk(1, 1, 1, 13, 5));
    wr(1, 0, mk(4, 1, 1, 15, 4));
    ch_tx = 6'b101001;
    run_frame(0);
  endtask

  initial begin
    t_reset();
    t_mixed();
    t_strobe_off();
    t_b2b();
    t_error();
    t_long();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule